// File: doc/BRIEF.md
# Serial Stream Byte Receiver with Headroom Flow Control

This block receives a serial byte stream as a slave. A sender supplies a bit clock, a framing strobe and a data line. The block samples all three into the system clock domain and builds bytes from the bits. It stores each finished byte in a 64-entry byte queue. A consumer empties the queue through a simple read-strobe port.

The sampling edge of the bit clock can be set to rising or falling. The bit order can be set to LSB-first or MSB-first. The framing strobe realigns the bit counter: the first sampling edge on which the strobe is high begins a new byte. A sender that keeps the strobe high all the time must keep byte alignment itself.

The request output tells the sender whether a 32-byte burst still fits in the queue. The sender checks it only between bursts. A byte that is already being received is always completed, even if the request output drops during it.

Top module: `sdi_rx`

## Requirements
- R1: When `cfg_fall` is 0, bits are sampled on rising edges of `ser_clk`. When `cfg_fall` is 1, bits are sampled on falling edges. Edges of the other direction take no bit.
- R2: A sampling edge on which `ser_sync` is high, where the previous sampling edge saw it low (or where it is the first sampling edge since reset), takes bit 0 of a new byte. Any partial byte is discarded.
- R3: When `cfg_msb` is 0, the first bit of a byte is stored in bit 0 and later bits go to higher positions. When `cfg_msb` is 1, the first bit is stored in bit 7 and later bits go to lower positions.
- R4: While `ser_sync` stays high, it causes no further realignment. Each group of 8 sampled bits then forms one byte.
- R5: `data_req` is 1 when at least 32 of the 64 queue entries are free, and 0 otherwise. It does not stop reception: a byte completed while `data_req` is 0 is still stored if the queue has room.
- R6: Bytes leave the queue in arrival order. `rd_data` shows the oldest byte while `rd_valid` is 1. A high `rd_en` pops that byte, and it is ignored while `rd_valid` is 0.
- R7: A byte completed while the queue holds 64 entries is dropped and sets `ovf`. `ovf` stays set until a cycle with `ovf_clr` high, and the clear wins over a new overflow in the same cycle.
- R8: After reset the queue is empty, `rd_valid` is 0, `data_req` is 1, `ovf` is 0 and the bit counter is at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fall | input | 1 | 1: sample on falling bit-clock edge |
| cfg_msb | input | 1 | 1: MSB-first bit order |
| ser_clk | input | 1 | Serial bit clock, at most a quarter of clk |
| ser_sync | input | 1 | Byte framing strobe |
| ser_dat | input | 1 | Serial data |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest byte in the queue |
| rd_valid | output | 1 | Queue not empty |
| data_req | output | 1 | At least 32 entries free |
| ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears `ovf` |

## Verification
The bench first shifts in three stray bits without the strobe, then sends a framed byte. A receiver that failed to realign would store a shifted value or an extra byte. It streams two bytes with the strobe held high throughout, which catches a design that realigns on the strobe level rather than on its first high sample. It fills the queue to exactly 32 and then 33 entries to find an off-by-one in the request threshold. It also checks that a byte completed while the request is low is still stored. The last group of tests writes a 65th byte into a full queue and pops while the queue is empty. A design that overwrote the oldest entry, or whose pointers moved on an empty pop, would return wrong data or a wrong count.

// File: rtl/sdi_rx.sv
module sdi_rx #(
  parameter int DEPTH    = 64,
  parameter int HEADROOM = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_fall,
  input  logic       cfg_msb,
  input  logic       ser_clk,
  input  logic       ser_sync,
  input  logic       ser_dat,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       data_req,
  output logic       ovf,
  input  logic       ovf_clr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [2:0] clk_s;
  logic [1:0] sync_s, dat_s;
  logic       sync_last;
  logic [2:0] bit_idx;
  logic [7:0] shreg;
  logic [7:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_s  <= '0;
      sync_s <= '0;
      dat_s  <= '0;
    end else begin
      clk_s  <= {clk_s[1:0], ser_clk};
      sync_s <= {sync_s[0], ser_sync};
      dat_s  <= {dat_s[0], ser_dat};
    end
  end

  wire rise    = clk_s[1] & ~clk_s[2];
  wire fall    = ~clk_s[1] & clk_s[2];
  wire edge_s  = cfg_fall ? fall : rise;
  wire realign = edge_s & sync_s[1] & ~sync_last;
  wire [2:0] idx_eff = realign ? 3'd0 : bit_idx;
  wire [2:0] pos     = cfg_msb ? 3'd7 - idx_eff : idx_eff;

  logic [7:0] asm_byte;
  always_comb begin
    asm_byte      = shreg;
    asm_byte[pos] = dat_s[1];
  end

  wire byte_done = edge_s & (idx_eff == 3'd7);
  wire full      = (count == CW'(DEPTH));
  wire push      = byte_done & ~full;
  wire pop       = rd_en & rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_last <= 1'b0;
      bit_idx   <= '0;
      shreg     <= '0;
    end else if (edge_s) begin
      sync_last <= sync_s[1];
      bit_idx   <= idx_eff + 3'd1;
      shreg     <= (idx_eff == 3'd7) ? 8'h00 : asm_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= asm_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      ovf   <= ovf_clr ? 1'b0 : (ovf | (byte_done & full));
    end
  end

  assign rd_data  = mem[rp];
  assign rd_valid = (count != '0);
  assign data_req = (CW'(DEPTH) - count) >= CW'(HEADROOM);
endmodule

// File: rtl/sdi_rx_chk.sv
module sdi_rx_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          data_req,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          ovf,
  input logic          ovf_clr,
  input logic          byte_done,
  input logic          realign,
  input logic [2:0]    bit_idx,
  input logic [CW-1:0] count
);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);
  a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> !ovf);
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    count == CW'(DEPTH) && !rd_en |=> count == CW'(DEPTH));
  a_r5_dreq_falls_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_req) |-> $past(byte_done));
  a_r6_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid && !byte_done |=> count == '0);
  a_r2_realign_restart: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> bit_idx == 3'd1);
  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

bind sdi_rx sdi_rx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_req(data_req), .rd_en(rd_en),
  .rd_valid(rd_valid), .ovf(ovf), .ovf_clr(ovf_clr), .byte_done(byte_done),
  .realign(realign), .bit_idx(bit_idx), .count(count)
);

// File: tb/sdi_rx_bench.sv
module sdi_rx_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_fall = 0, cfg_msb = 0;
  logic ser_clk = 0, ser_sync = 0, ser_dat = 0;
  logic rd_en = 0, ovf_clr = 0;
  logic [7:0] rd_data;
  logic rd_valid, data_req, ovf;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  sdi_rx u_sdi_rx (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input bit msb, input bit fallm);
    cfg_msb = msb; cfg_fall = fallm;
    wt(2);
    ser_clk = fallm;
    wt(6);
  endtask

  // mode 0: no strobe, 1: strobe on first bit, 2: strobe held high
  task automatic send(input logic [7:0] b, input int nbits, input int mode);
    for (int i = 0; i < nbits; i++) begin
      ser_dat  = cfg_msb ? b[7-i] : b[i];
      ser_sync = (mode == 2) || (mode == 1 && i == 0);
      wt(4); ser_clk = ~ser_clk;
      wt(4); ser_clk = ~ser_clk;
    end
    ser_sync = (mode == 2);
    wt(6);
  endtask

  task automatic pop(input string req, input logic [7:0] exp);
    chk(req, rd_valid, 1);
    chk(req, rd_data, exp);
    rd_en = 1; wt(1); rd_en = 0;
  endtask

  task automatic t_reset;
    chk("R8 valid", rd_valid, 0);
    chk("R8 dreq", data_req, 1);
    chk("R8 ovf", ovf, 0);
  endtask

  task automatic t_lsb_rise;
    set_mode(0, 0);
    send(8'hA5, 8, 1);
    send(8'h01, 8, 1);
    pop("R3 lsb", 8'hA5);
    pop("R1 rising", 8'h01);
    chk("R6 drained", rd_valid, 0);
  endtask

  task automatic t_msb;
    set_mode(1, 0);
    send(8'h3C, 8, 1);
    send(8'h80, 8, 1);
    pop("R3 msb", 8'h3C);
    pop("R3 msb top", 8'h80);
  endtask

  task automatic t_fall;
    set_mode(0, 1);
    send(8'h5A, 8, 1);
    send(8'hC3, 8, 1);
    pop("R1 falling", 8'h5A);
    pop("R1 falling 2", 8'hC3);
    set_mode(0, 0);
  endtask

  task automatic t_realign;
    send(8'hFF, 3, 0);
    send(8'h96, 8, 1);
    pop("R2 realign", 8'h96);
    chk("R2 single byte", rd_valid, 0);
  endtask

  task automatic t_held;
    ser_sync = 0; wt(2);
    send(8'h12, 8, 2);
    send(8'hED, 8, 2);
    pop("R4 first", 8'h12);
    pop("R4 second", 8'hED);
    chk("R4 count", rd_valid, 0);
    ser_sync = 0;
  endtask

  task automatic t_dreq;
    for (int i = 0; i < 32; i++) send(8'(i), 8, 1);
    chk("R5 32 free", data_req, 1);
    send(8'h20, 8, 1);
    chk("R5 31 free", data_req, 0);
    send(8'h21, 8, 1);
    chk("R5 still low", data_req, 0);
    for (int i = 0; i < 34; i++) pop("R5 data", 8'(i));
    chk("R5 recovered", data_req, 1);
  endtask

  task automatic t_ovf;
    for (int i = 0; i < 64; i++) send(8'(i + 100), 8, 1);
    chk("R7 no ovf yet", ovf, 0);
    send(8'hEE, 8, 1);
    chk("R7 ovf set", ovf, 1);
    wt(5);
    chk("R7 sticky", ovf, 1);
    for (int i = 0; i < 64; i++) pop("R7 kept", 8'(i + 100));
    chk("R7 dropped", rd_valid, 0);
    ovf_clr = 1; wt(1); ovf_clr = 0;
    chk("R7 cleared", ovf, 0);
  endtask

  task automatic t_empty_pop;
    rd_en = 1; wt(3); rd_en = 0;
    chk("R6 empty pop", rd_valid, 0);
    send(8'h77, 8, 1);
    pop("R6 after empty pop", 8'h77);
    chk("R6 empty", rd_valid, 0);
  endtask

  initial begin
    wt(4); rst_n = 1; wt(2);
    t_reset();
    t_lsb_rise();
    t_msb();
    t_fall();
    set_mode(0, 0);
    t_realign();
    t_held();
    t_dreq();
    t_ovf();
    t_empty_pop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule